// File: doc/BRIEF.md
# Receive Buffer Timed Flush Controller

This block decides when the bytes waiting in a receive buffer should be handed to the upstream packet interface. It watches three things: the buffer's fill level, each byte as it is written into the buffer, and a free-running 1 ms strobe. A latency timer counts milliseconds while the buffer holds data. The block raises a flush request when that timer reaches a programmed limit, when the buffer becomes full, or when a chosen event character arrives.

The flush request is a valid/ready handshake. `flush_req` is the valid and `flush_ack` is the ready. Once raised, the request stays high until the consumer accepts it. The consumer applies back-pressure simply by holding `flush_ack` low, and no trigger is lost or duplicated while it waits. The byte strobe is only observed, so it carries no ready. The timeout register is loaded through a plain write strobe. It resets to 16 ms, and values from 1 to 255 ms can be written.

Top module: `rx_flush_ctrl`

## Requirements
- R1: After reset `flush_req` is 0, and the timeout register holds 16, so a non-empty buffer is flushed after 16 ms ticks.
- R2: A cycle with `tmo_wr` high loads `tmo_wdata` into the timeout register. A stored value of 0 behaves exactly like 1.
- R3: The latency timer advances by one on each `ms_tick` cycle, and only while `buf_count` is non-zero. A cycle with `buf_count` equal to 0 clears it to zero.
- R4: With a non-empty buffer, `flush_req` becomes visible two clock edges after the cycle carrying the N-th tick, where N is the effective timeout. It is never raised before that tick.
- R5: When `buf_count` is DEPTH or more, `flush_req` rises at the next clock edge, whatever the timer holds.
- R6: A cycle with `rx_valid`, `evt_en` and `rx_data == evt_char` raises `flush_req` at the next edge, even if the buffer is empty. A mismatching byte, or any byte while `evt_en` is 0, raises nothing.
- R7: `flush_req` stays high until a cycle with `flush_ack` high. That handshake cycle clears it at the next edge.
- R8: Triggers that arrive while a request is pending merge into that request, and so do triggers in the handshake cycle itself. After a handshake the timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A byte is being written into the buffer this cycle |
| rx_data | input | DATA_W | The byte being written |
| buf_count | input | $clog2(DEPTH+1) | Current buffer fill level |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| tmo_wr | input | 1 | Write strobe for the timeout register |
| tmo_wdata | input | 8 | Timeout in milliseconds (0 acts as 1) |
| evt_char | input | DATA_W | Event character value |
| evt_en | input | 1 | Enables event-character flushing |
| flush_req | output | 1 | Flush request (valid) |
| flush_ack | input | 1 | Flush accepted (ready) |

## Verification
The bench builds the block with DEPTH = 16 instead of 384. The 5-bit fill-level port can then be swept over every value, including levels above capacity, and each one is checked against the full threshold. A fast one-cycle tick lets the bench sweep the timeout register through 0 to 40 plus 100 and 255, and check each tick count against the limit. All 256 byte values go past the event comparator. Dedicated sequences cover timer clearing on an empty buffer, merging while a request is pending, and restart after acknowledge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int TMO_W       = 8;
  localparam int TMO_DEFAULT = 16;

  function automatic logic [TMO_W-1:0] eff_timeout(input logic [TMO_W-1:0] v);
    return (v == '0) ? TMO_W'(1) : v;
  endfunction
endpackage

// File: rtl/rxf_tmo_reg.sv
module rxf_tmo_reg
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [TMO_W-1:0] wdata,
  output logic [TMO_W-1:0] eff_tmo
);
  logic [TMO_W-1:0] stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stored <= TMO_W'(TMO_DEFAULT);
    else if (wr) stored <= wdata;
  end

  assign eff_tmo = eff_timeout(stored);

  // R2
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(stored));
endmodule

// File: rtl/rxf_latency_timer.sv
module rxf_latency_timer
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             nonempty,
  input  logic             restart,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] ms_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ms_cnt <= '0;
    else if (restart || !nonempty)  ms_cnt <= '0;
    else if (tick && ms_cnt != '1)  ms_cnt <= ms_cnt + 1'b1;
  end

  assign expired = nonempty && (ms_cnt >= limit);

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nonempty && !tick && !restart) |=> $stable(ms_cnt));
  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ms_cnt == '0));
endmodule

// File: rtl/rxf_event_match.sv
module rxf_event_match #(
  parameter int DATA_W = 8
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] match_val,
  input  logic              enable,
  output logic              hit
);
  assign hit = valid && enable && (data == match_val);
endmodule

// File: rtl/rxf_req_hold.sv
module rxf_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic req
);
  logic handshake;
  assign handshake = req && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req <= 1'b0;
    else if (handshake) req <= 1'b0;
    else if (set)       req <= 1'b1;
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  // R7
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req);
  // R8
  req_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !handshake) |=> req);
endmodule

// File: rtl/rx_flush_ctrl.sv
module rx_flush_ctrl
  import rxf_pkg::*;
#(
  parameter int DEPTH  = 384,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [CNT_W-1:0]  buf_count,
  input  logic              ms_tick,
  input  logic              tmo_wr,
  input  logic [TMO_W-1:0]  tmo_wdata,
  input  logic [DATA_W-1:0] evt_char,
  input  logic              evt_en,
  output logic              flush_req,
  input  logic              flush_ack
);
  logic [TMO_W-1:0] eff_tmo;
  logic nonempty, full, tmo_hit, evt_hit, any_trig, handshake;

  assign nonempty  = (buf_count != '0);
  assign full      = (buf_count >= CNT_W'(DEPTH));
  assign handshake = flush_req && flush_ack;
  assign any_trig  = tmo_hit || full || evt_hit;

  rxf_tmo_reg tmo_i (
    .clk(clk), .rst_n(rst_n), .wr(tmo_wr), .wdata(tmo_wdata), .eff_tmo(eff_tmo)
  );

  rxf_latency_timer tmr_i (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .nonempty(nonempty),
    .restart(handshake), .limit(eff_tmo), .expired(tmo_hit)
  );

  rxf_event_match #(.DATA_W(DATA_W)) evt_i (
    .valid(rx_valid), .data(rx_data), .match_val(evt_char),
    .enable(evt_en), .hit(evt_hit)
  );

  rxf_req_hold req_i (
    .clk(clk), .rst_n(rst_n), .set(any_trig), .ack(flush_ack), .req(flush_req)
  );

  // R5
  full_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_count >= CNT_W'(DEPTH) && !(flush_req && flush_ack)) |=> flush_req);
  // R6
  evt_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && evt_en && rx_data == evt_char && !(flush_req && flush_ack)) |=> flush_req);
  // R4
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_req && !tmo_hit && !full && !evt_hit) |=> !flush_req);
endmodule

// File: tb/rx_flush_ctrl_tb_top.sv
module rx_flush_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, ms_tick = 0, tmo_wr = 0, evt_en = 0, flush_ack = 0;
  logic [7:0] rx_data = 0, tmo_wdata = 0, evt_char = 0;
  logic [CNT_W-1:0] buf_count = 0;
  logic flush_req;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_flush_ctrl #(.DEPTH(DEPTH), .DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .buf_count(buf_count), .ms_tick(ms_tick), .tmo_wr(tmo_wr),
    .tmo_wdata(tmo_wdata), .evt_char(evt_char), .evt_en(evt_en),
    .flush_req(flush_req), .flush_ack(flush_ack)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: flush_req=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic tick_pulse();
    ms_tick = 1; step(); ms_tick = 0; step();
  endtask

  task automatic do_ack();
    flush_ack = 1; step(); flush_ack = 0;
  endtask

  task automatic set_tmo(input logic [7:0] v);
    tmo_wr = 1; tmo_wdata = v; step(); tmo_wr = 0;
  endtask

  task automatic evt_pulse(input logic [7:0] d);
    rx_valid = 1; rx_data = d; step(); rx_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    chk(flush_req, 1'b0, "R1 reset");

    // R1 default 16 ms, R4 tick-exact
    buf_count = 5;
    for (int k = 1; k <= 16; k++) begin
      tick_pulse();
      chk(flush_req, k >= 16, "R1 default timeout");
    end
    do_ack();
    chk(flush_req, 1'b0, "R7 ack clears");

    // R2/R4 timeout sweep, R7 hold
    buf_count = 3;
    for (int i = 0; i < 43; i++) begin
      automatic int t = (i <= 40) ? i : ((i == 41) ? 100 : 255);
      automatic int eff = (t == 0) ? 1 : t;
      set_tmo(8'(t));
      do_ack();
      for (int k = 1; k <= eff; k++) begin
        tick_pulse();
        chk(flush_req, k >= eff, "R4 timeout sweep");
      end
      step(); step();
      chk(flush_req, 1'b1, "R7 held without ack");
      do_ack();
      chk(flush_req, 1'b0, "R2 ack after sweep");
    end

    // R3 empty clears timer
    set_tmo(8'd5);
    buf_count = 2;
    repeat (3) tick_pulse();
    buf_count = 0;
    for (int k = 0; k < 4; k++) begin
      tick_pulse();
      chk(flush_req, 1'b0, "R3 no count while empty");
    end
    buf_count = 2;
    for (int k = 1; k <= 5; k++) begin
      tick_pulse();
      chk(flush_req, k >= 5, "R3 timer cleared by empty");
    end
    do_ack();

    // R5 full sweep
    set_tmo(8'd255);
    for (int c = 0; c < (1 << CNT_W); c++) begin
      buf_count = CNT_W'(c);
      step();
      chk(flush_req, c >= DEPTH, "R5 full threshold");
      if (flush_req) begin
        buf_count = 1;
        do_ack();
      end
    end

    // R6 event sweep
    buf_count = 1;
    evt_char = 8'h0D;
    evt_en = 1;
    for (int d = 0; d < 256; d++) begin
      evt_pulse(8'(d));
      chk(flush_req, d == 8'h0D, "R6 event match");
      if (flush_req) do_ack();
    end
    evt_en = 0;
    evt_pulse(8'h0D);
    chk(flush_req, 1'b0, "R6 disabled event");
    evt_en = 1;
    buf_count = 0;
    evt_pulse(8'h0D);
    chk(flush_req, 1'b1, "R6 event with empty buffer");
    do_ack();

    // R8 merge and restart
    set_tmo(8'd3);
    buf_count = 4;
    evt_pulse(8'h0D);
    chk(flush_req, 1'b1, "R8 first trigger");
    repeat (3) tick_pulse();
    evt_pulse(8'h0D);
    do_ack();
    chk(flush_req, 1'b0, "R8 merged triggers give one request");
    for (int k = 1; k <= 3; k++) begin
      tick_pulse();
      chk(flush_req, k >= 3, "R8 timer restart after ack");
    end
    rx_valid = 1; rx_data = 8'h0D; flush_ack = 1; step();
    rx_valid = 0; flush_ack = 0;
    chk(flush_req, 1'b0, "R8 trigger in ack cycle absorbed");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule